// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps precise time for a network port that timestamps packets under IEEE 1588. It holds a 48-bit seconds count and a 30-bit nanoseconds count. On every clock cycle it adds a programmable step to the nanoseconds. The step has a whole-nanosecond part and a 16-bit binary fraction. The fraction builds up in an accumulator, and each carry out of that accumulator adds one extra nanosecond. When the nanoseconds reach one billion they fold back and the seconds go up by one.

Software reaches the counter through a small word-wide register port with one write strobe. Through it, software can:
- read the live time;
- set the nanoseconds;
- set the seconds as two words that take effect together;
- load a new step in two writes that take effect together;
- move the time forward or back once with a signed nanosecond offset.

Offsets of a second or more go through setting the time, not through the offset register. Loading a zero step stops the counter. The current time is also driven out on two ports for local consumers.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, the nanoseconds and seconds are zero. The active step is RST_INC_NS whole nanoseconds (default 5) plus RST_INC_SUB fractional units (default 0).
- R2: When no write is made, the nanoseconds advance each cycle by the active whole step plus the carry out of a 16-bit fraction accumulator, to which the active fraction is added every cycle.
- R3: When the advanced nanoseconds reach 1,000,000,000, they wrap to the remainder and the 48-bit seconds increase by one. This carry crosses from the low 32 bits into the high 16 bits.
- R4: A write to the step fraction register (address 4, bits 15:0) is held aside and does not change the active fraction. A later write to the whole-step register (address 3, bits 7:0) loads both the whole step and the held fraction, and they are used from the next cycle on.
- R5: A write to the seconds high register (address 2, bits 15:0) alone leaves the running seconds unchanged. A write to the seconds low register (address 1, bits 31:0) loads all 48 seconds from the held high word and the written low word.
- R6: A write to the nanoseconds register (address 0, bits 29:0) sets the nanoseconds to exactly that value in that cycle. No step is added and no seconds carry occurs in that cycle. Writing zero clears it.
- R7: A write to the offset register (address 5) carries a magnitude in bits 29:0, which must be below 1,000,000,000, and a sign in bit 31.
  - With the sign clear, the magnitude is added to that cycle's advanced time once; with it set, the magnitude is subtracted.
  - A result below zero borrows one second; a result of one billion or more carries one second.
- R8: Once both step registers are loaded with zero, the nanoseconds hold still for as long as no time write or offset arrives.
- R9: Reads are combinational and return live values:
  - address 0: nanoseconds;
  - address 1: seconds bits 31:0;
  - address 2: seconds bits 47:32;
  - address 3: active whole step;
  - address 4: active fraction.
  Address 5 reads zero. Addresses 6 and 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Live read data for bus_addr |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
The hardest situations to reach from the ports are an offset whose result crosses a second boundary in either direction, and a nanosecond rollover that carries from the low seconds word into the high word. At the default step, the counter would need about 200 million cycles to reach a rollover by itself. The stimulus therefore first writes the nanoseconds close to one billion or close to zero, then applies an offset or lets the counter run a few cycles. The random phase biases its nanosecond writes toward the last thousand values before the wrap, and it mixes in offsets of both signs, step changes and partial seconds writes.

// File: rtl/ptp_tod_pkg.sv
`timescale 1ns/1ps
package ptp_tod_pkg;

    typedef enum logic [2:0] {
        SEL_NS      = 3'd0,
        SEL_SEC_LO  = 3'd1,
        SEL_SEC_HI  = 3'd2,
        SEL_INC_NS  = 3'd3,
        SEL_INC_SUB = 3'd4,
        SEL_ADJ     = 3'd5
    } tod_sel_e;

    typedef struct packed {
        logic ns;
        logic sec_lo;
        logic sec_hi;
        logic inc_ns;
        logic inc_sub;
        logic adj;
    } tod_wr_t;

endpackage

// File: rtl/ptp_tod_decode.sv
`timescale 1ns/1ps
module ptp_tod_decode
    import ptp_tod_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output tod_wr_t           wr_o
);

    always_comb begin
        wr_o         = '0;
        wr_o.ns      = bus_wr && (bus_addr == ADDR_W'(SEL_NS));
        wr_o.sec_lo  = bus_wr && (bus_addr == ADDR_W'(SEL_SEC_LO));
        wr_o.sec_hi  = bus_wr && (bus_addr == ADDR_W'(SEL_SEC_HI));
        wr_o.inc_ns  = bus_wr && (bus_addr == ADDR_W'(SEL_INC_NS));
        wr_o.inc_sub = bus_wr && (bus_addr == ADDR_W'(SEL_INC_SUB));
        wr_o.adj     = bus_wr && (bus_addr == ADDR_W'(SEL_ADJ));
    end

endmodule

// File: rtl/ptp_tod_step.sv
`timescale 1ns/1ps
module ptp_tod_step #(
    parameter int NS_INC_W    = 8,
    parameter int SUB_W       = 16,
    parameter int RST_INC_NS  = 5,
    parameter int RST_INC_SUB = 0,
    localparam int STEP_W     = NS_INC_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_inc_ns,
    input  logic                wr_inc_sub,
    input  logic [NS_INC_W-1:0] inc_ns_wdata,
    input  logic [SUB_W-1:0]    inc_sub_wdata,
    output logic [STEP_W-1:0]   step_ns_o,
    output logic [NS_INC_W-1:0] inc_ns_o,
    output logic [SUB_W-1:0]    inc_sub_o
);

    typedef struct packed {
        logic [NS_INC_W-1:0] inc_ns;
        logic [SUB_W-1:0]    inc_sub;
        logic [SUB_W-1:0]    sub_shadow;
        logic [SUB_W-1:0]    frac;
    } step_state_t;

    step_state_t st_d, st_q;
    logic        frac_carry;

    always_comb begin
        st_d = st_q;
        {frac_carry, st_d.frac} = {1'b0, st_q.frac} + {1'b0, st_q.inc_sub};
        step_ns_o = {1'b0, st_q.inc_ns} + {{NS_INC_W{1'b0}}, frac_carry};
        if (wr_inc_sub) begin
            st_d.sub_shadow = inc_sub_wdata;
        end
        if (wr_inc_ns) begin
            st_d.inc_ns  = inc_ns_wdata;
            st_d.inc_sub = st_q.sub_shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.inc_ns     <= NS_INC_W'(RST_INC_NS);
            st_q.inc_sub    <= SUB_W'(RST_INC_SUB);
            st_q.sub_shadow <= SUB_W'(RST_INC_SUB);
            st_q.frac       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc_ns_o  = st_q.inc_ns;
    assign inc_sub_o = st_q.inc_sub;

    // R4: a lone fraction write must not disturb the active fraction
    assert_sub_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inc_sub && !wr_inc_ns) |=> (st_q.inc_sub == $past(st_q.inc_sub)));

    // R4: whole-step write moves the held fraction into service
    assert_sub_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inc_ns |=> (st_q.inc_sub == $past(st_q.sub_shadow)));

endmodule

// File: rtl/ptp_tod_clock.sv
`timescale 1ns/1ps
module ptp_tod_clock #(
    parameter int DATA_W     = 32,
    parameter int SEC_LO_W   = 32,
    parameter int SEC_HI_W   = 16,
    parameter int NS_PER_SEC = 1_000_000_000,
    parameter int STEP_W     = 9,
    localparam int NS_W      = $clog2(NS_PER_SEC),
    localparam int SEC_W     = SEC_LO_W + SEC_HI_W,
    localparam int SUM_W     = NS_W + 3,
    localparam int SIGN_BIT  = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ns,
    input  logic              wr_sec_lo,
    input  logic              wr_sec_hi,
    input  logic              wr_adj,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STEP_W-1:0] step_ns,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   ns_o
);

    localparam logic signed [SUM_W-1:0] NS_LIMIT = SUM_W'(NS_PER_SEC);

    typedef struct packed {
        logic [SEC_W-1:0]    sec;
        logic [NS_W-1:0]     ns;
        logic [SEC_HI_W-1:0] hi_shadow;
    } clk_state_t;

    clk_state_t              st_d, st_q;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] mag;

    always_comb begin
        st_d = st_q;
        mag  = $signed({{(SUM_W-NS_W){1'b0}}, wdata[NS_W-1:0]});
        sum  = $signed({{(SUM_W-NS_W){1'b0}}, st_q.ns})
             + $signed({{(SUM_W-STEP_W){1'b0}}, step_ns});
        if (wr_adj) begin
            if (wdata[SIGN_BIT]) begin
                sum = sum - mag;
            end else begin
                sum = sum + mag;
            end
        end
        if (wr_ns) begin
            st_d.ns = wdata[NS_W-1:0];
        end else begin
            if (sum < 0) begin
                sum      = sum + NS_LIMIT;
                st_d.sec = st_q.sec - 1'b1;
            end else if (sum >= NS_LIMIT) begin
                sum      = sum - NS_LIMIT;
                st_d.sec = st_q.sec + 1'b1;
            end
            st_d.ns = sum[NS_W-1:0];
        end
        if (wr_sec_hi) begin
            st_d.hi_shadow = wdata[SEC_HI_W-1:0];
        end
        if (wr_sec_lo) begin
            st_d.sec = {st_q.hi_shadow, wdata[SEC_LO_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;
    assign ns_o  = st_q.ns;

    // R3: the nanosecond count never leaves its legal range
    assert_ns_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ns < NS_W'(NS_PER_SEC));

    // R5: outside a low-word write, seconds move by at most one
    assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_sec_lo) && (st_q.sec != $past(st_q.sec))) |->
        ((st_q.sec == $past(st_q.sec) + 1'b1) || (st_q.sec == $past(st_q.sec) - 1'b1)));

    // R8: a zero step with no time write leaves nanoseconds still
    assert_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_ns == '0) && !wr_ns && !wr_adj) |=> $stable(st_q.ns));

endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32,
    parameter int NS_INC_W    = 8,
    parameter int SUB_W       = 16,
    parameter int SEC_LO_W    = 32,
    parameter int SEC_HI_W    = 16,
    parameter int NS_PER_SEC  = 1_000_000_000,
    parameter int RST_INC_NS  = 5,
    parameter int RST_INC_SUB = 0,
    localparam int NS_W       = $clog2(NS_PER_SEC),
    localparam int SEC_W      = SEC_LO_W + SEC_HI_W,
    localparam int STEP_W     = NS_INC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);

    tod_wr_t             wr;
    logic [STEP_W-1:0]   step_ns;
    logic [NS_INC_W-1:0] inc_ns;
    logic [SUB_W-1:0]    inc_sub;

    ptp_tod_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_o     (wr)
    );

    ptp_tod_step #(
        .NS_INC_W    (NS_INC_W),
        .SUB_W       (SUB_W),
        .RST_INC_NS  (RST_INC_NS),
        .RST_INC_SUB (RST_INC_SUB)
    ) u_step (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_inc_ns     (wr.inc_ns),
        .wr_inc_sub    (wr.inc_sub),
        .inc_ns_wdata  (bus_wdata[NS_INC_W-1:0]),
        .inc_sub_wdata (bus_wdata[SUB_W-1:0]),
        .step_ns_o     (step_ns),
        .inc_ns_o      (inc_ns),
        .inc_sub_o     (inc_sub)
    );

    ptp_tod_clock #(
        .DATA_W     (DATA_W),
        .SEC_LO_W   (SEC_LO_W),
        .SEC_HI_W   (SEC_HI_W),
        .NS_PER_SEC (NS_PER_SEC),
        .STEP_W     (STEP_W)
    ) u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ns     (wr.ns),
        .wr_sec_lo (wr.sec_lo),
        .wr_sec_hi (wr.sec_hi),
        .wr_adj    (wr.adj),
        .wdata     (bus_wdata),
        .step_ns   (step_ns),
        .sec_o     (tod_sec),
        .ns_o      (tod_ns)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(SEL_NS):      bus_rdata = DATA_W'(tod_ns);
            ADDR_W'(SEL_SEC_LO):  bus_rdata = DATA_W'(tod_sec[SEC_LO_W-1:0]);
            ADDR_W'(SEL_SEC_HI):  bus_rdata = DATA_W'(tod_sec[SEC_W-1:SEC_LO_W]);
            ADDR_W'(SEL_INC_NS):  bus_rdata = DATA_W'(inc_ns);
            ADDR_W'(SEL_INC_SUB): bus_rdata = DATA_W'(inc_sub);
            default:              bus_rdata = '0;
        endcase
    end

    // R9: the offset register never reads back its written value
    assert_adj_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(SEL_ADJ)) |-> (bus_rdata == '0));

endmodule

// File: tb/ptp_tod_counter_bench.sv
`timescale 1ns/1ps
module ptp_tod_counter_bench;

    localparam longint NSEC    = 1_000_000_000;
    localparam longint SECMASK = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    longint m_ns, m_sec;
    int     m_frac, m_sub, m_sub_sh, m_inc, m_hi_sh;

    ptp_tod_counter u_ptp_tod_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tod_sec   (tod_sec),
        .tod_ns    (tod_ns)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return 32'(m_ns);
            1: return 32'(m_sec & 64'hFFFF_FFFF);
            2: return 32'((m_sec >> 32) & 64'hFFFF);
            3: return 32'(m_inc);
            4: return 32'(m_sub);
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_ns = 0; m_sec = 0; m_frac = 0;
        m_inc = 5; m_sub = 0; m_sub_sh = 0; m_hi_sh = 0;
    endtask

    task automatic model_step(input bit wr, input int a, input logic [31:0] d);
        longint s;
        longint mag;
        int     carry;
        carry  = ((m_frac + m_sub) >> 16) & 1;
        m_frac = (m_frac + m_sub) & 32'hFFFF;
        s = m_ns + m_inc + carry;
        if (wr && a == 5) begin
            mag = longint'(d[29:0]);
            if (d[31]) s = s - mag;
            else       s = s + mag;
        end
        if (wr && a == 0) begin
            m_ns = longint'(d[29:0]);
        end else begin
            if (s < 0) begin
                s = s + NSEC;
                m_sec = (m_sec - 1) & SECMASK;
            end else if (s >= NSEC) begin
                s = s - NSEC;
                m_sec = (m_sec + 1) & SECMASK;
            end
            m_ns = s;
        end
        if (wr && a == 2) m_hi_sh = int'(d[15:0]);
        if (wr && a == 1) m_sec = (longint'(m_hi_sh) << 32) | longint'(d);
        if (wr && a == 4) m_sub_sh = int'(d[15:0]);
        if (wr && a == 3) begin
            m_inc = int'(d[7:0]);
            m_sub = m_sub_sh;
        end
    endtask

    task automatic op(input bit wr, input int a, input logic [31:0] d);
        bus_wr    = wr;
        bus_addr  = 3'(a);
        bus_wdata = d;
        @(posedge clk);
        model_step(wr, a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 0, 32'd0);
    endtask

    task automatic chk(input int a, input string tag);
        logic [31:0] got, exp;
        bus_addr = 3'(a);
        #0.1;
        got = bus_rdata;
        exp = exp_read(a);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual 0x%08h expected 0x%08h", tag, a, got, exp);
        end
    endtask

    task automatic chk_time(input string tag);
        chk(0, tag);
        chk(1, tag);
        chk(2, tag);
    endtask

    task automatic chk_all(input string tag);
        chk_time(tag);
        chk(3, tag);
        chk(4, tag);
    endtask

    initial begin
        longint held;
        void'($urandom(32'd1588));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_all("R1");

        // R2: base step of 5 ns per cycle
        idle(10);
        chk_time("R2");

        // R4: fraction write held until whole-step write
        op(1'b1, 4, 32'h0000_8000);
        chk(4, "R4");
        idle(3);
        chk_time("R4");
        op(1'b1, 3, 32'd3);
        chk(3, "R4");
        chk(4, "R4");
        idle(7);
        chk_time("R2");

        // R3: wrap into seconds
        op(1'b1, 0, 32'd999_999_995);
        idle(3);
        chk_time("R3");

        // R3: carry across seconds low/high words
        op(1'b1, 2, 32'd0);
        op(1'b1, 1, 32'hFFFF_FFFF);
        op(1'b1, 0, 32'd999_999_999);
        idle(1);
        chk_time("R3");

        // R5: high word alone has no effect, low write commits
        op(1'b1, 2, 32'h0000_ABCD);
        chk(2, "R5");
        chk(1, "R5");
        op(1'b1, 1, 32'h1234_5678);
        chk_time("R5");

        // R6: direct nanosecond writes, including clear
        op(1'b1, 0, 32'd123_456_789);
        chk(0, "R6");
        op(1'b1, 0, 32'd0);
        chk_time("R6");

        // R7: positive offset crossing a second
        op(1'b1, 0, 32'd999_999_000);
        op(1'b1, 5, 32'd2000);
        chk_time("R7");
        // R7: negative offset borrowing a second
        op(1'b1, 5, 32'h8000_0000 | 32'd5000);
        chk_time("R7");
        // R7: negative offset without borrow
        op(1'b1, 0, 32'd500_000_000);
        op(1'b1, 5, 32'h8000_0000 | 32'd400_000_000);
        chk_time("R7");

        // R8: zero step stops time
        op(1'b1, 4, 32'd0);
        op(1'b1, 3, 32'd0);
        idle(2);
        held = m_ns;
        idle(20);
        chk_time("R8");
        if (m_ns != held) begin
            errors++;
            $display("FAIL R8 model: actual %0d expected %0d", m_ns, held);
        end

        // R9: unused addresses ignored, offset reads zero
        op(1'b1, 6, 32'hFFFF_FFFF);
        op(1'b1, 7, 32'h3B9A_C9FF);
        chk_all("R9");
        chk(5, "R9");
        chk(6, "R9");
        chk(7, "R9");

        // random mix
        op(1'b1, 4, 32'h0000_4CCD);
        op(1'b1, 3, 32'd6);
        for (int k = 0; k < 3000; k++) begin
            int r;
            logic [31:0] d;
            r = int'($urandom % 16);
            case (r)
                0: op(1'b1, 0, 32'(999_999_000 + ($urandom % 1000)));
                1: op(1'b1, 0, 32'($urandom % 1_000_000_000));
                2: op(1'b1, 2, $urandom);
                3: op(1'b1, 1, $urandom);
                4: op(1'b1, 4, $urandom);
                5: op(1'b1, 3, 32'(1 + ($urandom % 255)));
                6, 7: begin
                    d = 32'($urandom % 1_000_000_000);
                    d[31] = $urandom % 2;
                    op(1'b1, 5, d);
                end
                8: op(1'b1, 0, 32'($urandom % 200));
                9: op(1'b1, 6 + int'($urandom % 2), $urandom);
                default: op(1'b0, 0, 32'd0);
            endcase
            chk_time("R2 R3 R7 random");
        end
        chk_all("R9 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule